// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block samples up to eight asynchronous interrupt pins, turns each into a clocked condition chosen per pin (an edge type or an active level), and holds the result in a pending flag. Each pin then drives its own interrupt line toward a parent controller. The line is gated by a per-pin mask bit and a per-pin priority field. A priority of zero acts as a second way to silence a pin.

Software reaches the block through a flat register port with a 3-bit address, a 32-bit write word and a combinational 32-bit read word. There are five registers: condition select, priority, pending, mask-set and mask-clear. In every register, pin 0 sits in the most significant field. A pending flag is dropped by writing 0 to its bit in the pending register, and a 1 leaves it alone. The mask is changed only through the separate set and clear registers, so no read-modify-write is ever needed.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset the condition and priority registers read 0, the pending register reads 0, every pin is masked and every interrupt line is low.
- R2: The condition register (address 0) is read-write; pin n owns the 4-bit field at bits (7-n)*4+3 down to (7-n)*4, so pin 0 is bits 31:28.
- R3: Condition code 0 latches a falling edge, code 1 a rising edge and code 4 either edge; an edge of the other direction leaves the flag clear.
- R4: Code 2 latches while the pin is low and code 3 while it is high; the flag is re-set every cycle the level holds, so a clearing write during an active level has no lasting effect.
- R5: Codes 5 to 15 never set a pending flag, whatever the pin does.
- R6: The priority register (address 1) is read-write with pin n's 4-bit field at the same position as in R2; a field of 0 holds that pin's line low and any other value lets it through.
- R7: The pending register (address 2) reads pin n's flag at bit 7-n; a write clears each flag whose bit is written 0 and leaves each flag whose bit is written 1.
- R8: Writing 1 to bit 7-n at address 3 masks pin n, and writing 1 to bit 7-n at address 4 unmasks it; zero bits change nothing, and both addresses read as 0.
- R9: Line irq_out[n] is high exactly when pin n is pending, unmasked and has a nonzero priority; masking never drops a pending flag.
- R10: A pin change made between two clock edges is first visible in the pending flag after the third rising clock edge that follows it: two synchroniser stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Raw external interrupt pins, bit n is pin n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select (0 condition, 1 priority, 2 pending, 3 mask-set, 4 mask-clear) |
| wdata | input | 8*FIELD_W | Write data |
| rdata | output | 8*FIELD_W | Read data for the register at addr |
| irq_out | output | NUM_PINS | Interrupt line per pin toward the parent, bit n is pin n |

## Verification
The bench builds the block with its defaults: eight pins, 4-bit fields and two synchroniser stages. That gives a full 32-bit layout where pin 0's top-nibble placement and the reversed 8-bit pending and mask maps can all be checked. Because the synchroniser depth is the default, the exact three-edge latency of R10 can be tested both ways: the flag is still clear after two edges and set after the third. With all eight slots populated, distinct pins can sit in every condition code at once, including an illegal one, so cross-talk between fields would be seen.

// File: rtl/extpin_pkg.sv
package extpin_pkg;

    // Register slots: the pending and mask registers always span this many bits.
    localparam int SLOT_CNT = 8;

    // Register addresses; the set/clear split is part of the programming model.
    localparam logic [2:0] ADDR_COND  = 3'd0;
    localparam logic [2:0] ADDR_PRIO  = 3'd1;
    localparam logic [2:0] ADDR_PEND  = 3'd2;
    localparam logic [2:0] ADDR_MSET  = 3'd3;
    localparam logic [2:0] ADDR_MCLR  = 3'd4;

    // Condition codes held in each pin's field.
    localparam int COND_FALL = 0;
    localparam int COND_RISE = 1;
    localparam int COND_LOW  = 2;
    localparam int COND_HIGH = 3;
    localparam int COND_ANY  = 4;

endpackage

// File: rtl/extpin_sync.sv
module extpin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/extpin_detect.sv
module extpin_detect
    import extpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int FIELD_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         level,
    input  logic [NUM_PINS*FIELD_W-1:0] cond,
    output logic [NUM_PINS-1:0]         hit
);

    logic [NUM_PINS-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic [FIELD_W-1:0] code;
        assign code = cond[n*FIELD_W +: FIELD_W];

        always_comb begin
            case (int'(code))
                COND_FALL: hit[n] =  prev_q[n] & ~level[n];
                COND_RISE: hit[n] = ~prev_q[n] &  level[n];
                COND_LOW:  hit[n] = ~level[n];
                COND_HIGH: hit[n] =  level[n];
                COND_ANY:  hit[n] =  prev_q[n] ^  level[n];
                default:   hit[n] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/extpin_gate.sv
module extpin_gate #(
    parameter int NUM_PINS = 8,
    parameter int FIELD_W  = 4
) (
    input  logic [NUM_PINS-1:0]         pending,
    input  logic [NUM_PINS-1:0]         masked,
    input  logic [NUM_PINS*FIELD_W-1:0] prio,
    output logic [NUM_PINS-1:0]         irq
);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign irq[n] = pending[n] & ~masked[n] & (|prio[n*FIELD_W +: FIELD_W]);
    end

endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl
    import extpin_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int FIELD_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_in,
    input  logic                      wr_en,
    input  logic [2:0]                addr,
    input  logic [SLOT_CNT*FIELD_W-1:0] wdata,
    output logic [SLOT_CNT*FIELD_W-1:0] rdata,
    output logic [NUM_PINS-1:0]       irq_out
);

    localparam int BUS_W = SLOT_CNT * FIELD_W;
    localparam int CFG_W = NUM_PINS * FIELD_W;

    typedef struct packed {
        logic [CFG_W-1:0]    cond;
        logic [CFG_W-1:0]    prio;
        logic [NUM_PINS-1:0] pending;
        logic [NUM_PINS-1:0] masked;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [NUM_PINS-1:0] level_sync;
    logic [NUM_PINS-1:0] hit_now;
    logic [NUM_PINS-1:0] pend_now;
    logic [CFG_W-1:0]    cond_now;

    extpin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (level_sync)
    );

    extpin_detect #(
        .NUM_PINS (NUM_PINS),
        .FIELD_W  (FIELD_W)
    ) i_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level_sync),
        .cond  (state_q.cond),
        .hit   (hit_now)
    );

    extpin_gate #(
        .NUM_PINS (NUM_PINS),
        .FIELD_W  (FIELD_W)
    ) i_gate (
        .pending (state_q.pending),
        .masked  (state_q.masked),
        .prio    (state_q.prio),
        .irq     (irq_out)
    );

    assign pend_now = state_q.pending;
    assign cond_now = state_q.cond;

    // Next-state: register writes, flag latching (set wins over clear).
    always_comb begin
        state_d = state_q;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (wr_en && addr == ADDR_COND) begin
                state_d.cond[n*FIELD_W +: FIELD_W] = wdata[(SLOT_CNT-1-n)*FIELD_W +: FIELD_W];
            end
            if (wr_en && addr == ADDR_PRIO) begin
                state_d.prio[n*FIELD_W +: FIELD_W] = wdata[(SLOT_CNT-1-n)*FIELD_W +: FIELD_W];
            end
            if (wr_en && addr == ADDR_PEND && !wdata[SLOT_CNT-1-n]) begin
                state_d.pending[n] = 1'b0;
            end
            if (hit_now[n]) begin
                state_d.pending[n] = 1'b1;
            end
            if (wr_en && addr == ADDR_MSET && wdata[SLOT_CNT-1-n]) begin
                state_d.masked[n] = 1'b1;
            end
            if (wr_en && addr == ADDR_MCLR && wdata[SLOT_CNT-1-n]) begin
                state_d.masked[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cond    <= '0;
            state_q.prio    <= '0;
            state_q.pending <= '0;
            state_q.masked  <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    // Read view: pin 0 in the top field / top bit.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            case (addr)
                ADDR_COND: rdata[(SLOT_CNT-1-n)*FIELD_W +: FIELD_W] = state_q.cond[n*FIELD_W +: FIELD_W];
                ADDR_PRIO: rdata[(SLOT_CNT-1-n)*FIELD_W +: FIELD_W] = state_q.prio[n*FIELD_W +: FIELD_W];
                ADDR_PEND: rdata[SLOT_CNT-1-n] = state_q.pending[n];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/extpin_irq_chk.sv
module extpin_irq_chk
    import extpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int FIELD_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [2:0]                    addr,
    input logic [SLOT_CNT*FIELD_W-1:0]   wdata,
    input logic [NUM_PINS-1:0]           irq_out,
    input logic [NUM_PINS-1:0]           pend_now,
    input logic [NUM_PINS-1:0]           hit_now,
    input logic [NUM_PINS*FIELD_W-1:0]   cond_now
);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin

        // R8
        mask_set_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_MSET && wdata[SLOT_CNT-1-n]) |=> !irq_out[n]);

        // R6
        prio_zero_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_PRIO && wdata[(SLOT_CNT-1-n)*FIELD_W +: FIELD_W] == '0)
            |=> !irq_out[n]);

        // R9
        mask_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == ADDR_MSET || addr == ADDR_MCLR) && pend_now[n]) |=> pend_now[n]);

        // R5
        bad_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cond_now[n*FIELD_W +: FIELD_W]) > COND_ANY) |-> !hit_now[n]);

        // R7
        pending_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_now[n]) |-> $past(hit_now[n]));

        // R7
        zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_PEND && !wdata[SLOT_CNT-1-n] && !hit_now[n]) |=> !pend_now[n]);
    end

endmodule

bind extpin_irq_ctrl extpin_irq_chk #(
    .NUM_PINS (NUM_PINS),
    .FIELD_W  (FIELD_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq_out  (irq_out),
    .pend_now (pend_now),
    .hit_now  (hit_now),
    .cond_now (cond_now)
);

// File: tb/test_extpin_irq_ctrl.sv
module test_extpin_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'h00;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    extpin_irq_ctrl i_extpin_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pins),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq)
    );

    // Monitor: pops expected items and compares with the design's outputs.
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {24'h0, irq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_chk(string tag, bit is_irq, logic [31:0] exp);
        sb_item_t it;
        it.tag = tag; it.is_irq = is_irq; it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_reg(string tag, logic [2:0] a, logic [31:0] exp);
        addr = a;
        #1;
        push_chk(tag, 1'b0, exp);
    endtask

    task automatic expect_irq(string tag, logic [7:0] exp);
        push_chk(tag, 1'b1, {24'h0, exp});
    endtask

    task automatic set_pin(int n, logic v);
        @(negedge clk);
        pins[n] = v;
    endtask

    task automatic cycles(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [31:0] fld(int n, logic [3:0] v);
        return 32'(v) << ((7 - n) * 4);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        expect_reg("R1 cond after reset", 3'd0, 32'h0);
        expect_reg("R1 prio after reset", 3'd1, 32'h0);
        expect_reg("R1 pending after reset", 3'd2, 32'h0);
        expect_irq("R1 lines after reset", 8'h00);

        reg_write(3'd0, fld(0, 4'd1));
        expect_reg("R2 pin0 field in top nibble", 3'd0, 32'h1000_0000);
        reg_write(3'd1, 32'hF000_0000);
        expect_reg("R6 prio readback", 3'd1, 32'hF000_0000);
        reg_write(3'd4, 32'h80);

        // Rising edge on pin 0 with exact latency
        set_pin(0, 1'b1);
        cycles(2);
        expect_reg("R10 not yet pending after two edges", 3'd2, 32'h00);
        cycles(1);
        expect_reg("R10 R3 rising edge pending on third edge", 3'd2, 32'h80);
        expect_irq("R9 pin0 line", 8'h01);

        reg_write(3'd3, 32'h80);
        expect_irq("R8 mask set silences pin0", 8'h00);
        expect_reg("R9 masking keeps pending", 3'd2, 32'h80);
        reg_write(3'd4, 32'h80);
        expect_irq("R8 mask clear restores pin0", 8'h01);

        reg_write(3'd2, 32'hFF);
        expect_reg("R7 ones leave pending", 3'd2, 32'h80);
        reg_write(3'd2, 32'h7F);
        expect_reg("R7 zero clears pending", 3'd2, 32'h00);
        expect_irq("R9 line drops with flag", 8'h00);

        set_pin(0, 1'b0);
        cycles(3);
        expect_reg("R3 rising mode ignores fall", 3'd2, 32'h00);

        // Falling edge on pin 1
        reg_write(3'd1, 32'hF300_0000);
        reg_write(3'd4, 32'h40);
        set_pin(1, 1'b1);
        cycles(3);
        expect_reg("R3 falling mode ignores rise", 3'd2, 32'h00);
        set_pin(1, 1'b0);
        cycles(3);
        expect_reg("R3 falling edge pending", 3'd2, 32'h40);
        expect_irq("R9 pin1 line", 8'h02);
        reg_write(3'd2, 32'h00);
        expect_reg("R7 clear all", 3'd2, 32'h00);

        // High level on pin 2 with zero priority
        reg_write(3'd0, fld(0, 4'd1) | fld(2, 4'd3));
        reg_write(3'd4, 32'h20);
        set_pin(2, 1'b1);
        cycles(3);
        expect_reg("R4 high level pending", 3'd2, 32'h20);
        expect_irq("R6 zero prio blocks pin2", 8'h00);
        reg_write(3'd1, 32'hF3A0_0000);
        expect_irq("R6 nonzero prio passes pin2", 8'h04);
        reg_write(3'd2, 32'hDF);
        expect_reg("R4 clear during active level", 3'd2, 32'h20);
        set_pin(2, 1'b0);
        cycles(3);
        reg_write(3'd2, 32'hDF);
        expect_reg("R4 clear after level ends", 3'd2, 32'h00);
        expect_irq("R9 lines idle", 8'h00);

        // Low level on pin 3 (pin already low)
        reg_write(3'd0, 32'h1032_0000);
        cycles(3);
        expect_reg("R4 low level pending", 3'd2, 32'h10);
        reg_write(3'd0, 32'h1035_0000);
        reg_write(3'd2, 32'h00);
        set_pin(3, 1'b1);
        cycles(3);
        set_pin(3, 1'b0);
        cycles(3);
        expect_reg("R5 code 5 never pends", 3'd2, 32'h00);

        // Both edges on pin 4
        reg_write(3'd0, 32'h1035_4000);
        set_pin(4, 1'b1);
        cycles(3);
        expect_reg("R3 any-edge catches rise", 3'd2, 32'h08);
        reg_write(3'd2, 32'h00);
        set_pin(4, 1'b0);
        cycles(3);
        expect_reg("R3 any-edge catches fall", 3'd2, 32'h08);
        reg_write(3'd2, 32'h00);

        // Code 7 on pin 5
        reg_write(3'd0, 32'h1035_4700);
        expect_reg("R2 full readback", 3'd0, 32'h1035_4700);
        set_pin(5, 1'b1);
        cycles(3);
        set_pin(5, 1'b0);
        cycles(3);
        expect_reg("R5 code 7 never pends", 3'd2, 32'h00);

        // Zero writes to mask registers
        set_pin(1, 1'b1);
        cycles(3);
        set_pin(1, 1'b0);
        cycles(3);
        expect_irq("R9 pin1 line again", 8'h02);
        reg_write(3'd3, 32'h00);
        expect_irq("R8 zero mask-set write no effect", 8'h02);
        reg_write(3'd3, 32'h40);
        reg_write(3'd4, 32'h00);
        expect_irq("R8 zero mask-clear write no effect", 8'h00);
        expect_reg("R8 mask-set reads zero", 3'd3, 32'h0);
        expect_reg("R8 mask-clear reads zero", 3'd4, 32'h0);
        expect_reg("R9 pending survives mask", 3'd2, 32'h40);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule